// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block sits beside a small CPU core and decides which interrupt the core services next. It watches a set of hardware request lines and a software break request. It keeps a pending flag for each source, and it masks the hardware sources with enable bits held in two byte-wide enable registers. A global interrupt-enable flag (I) gates every hardware source. When a source wins, the controller raises a request toward the core with the winning index and a vector address. It holds both steady until the core takes the request with a one-cycle pulse.

Taking a request clears I, so a running handler is not disturbed. A handler that wants nesting sets I again, through the enable-interrupt input, after it has narrowed the enable registers to the sources it allows. A higher-priority source that is still enabled then raises a new request while the first handler is running. The break request has the lowest priority and uses the same vector as table-call entry 0. The controller keeps a break flag (B) so the shared handler can tell which of the two brought it there. The core's return path reloads I and B from the saved status word. The core itself, its stack and its instruction decoding lie outside the block.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, irq_req_o is 0, iflag_o is 0, bflag_o is 0 and both enable registers (ien_o) are 0.
- R2: A hardware source becomes pending on a 0-to-1 transition of its line. The take of that source clears the pending flag. A line that stays high after its take raises no new request.
- R3: Hardware source k takes part in arbitration only while its enable bit is 1. That bit is ien_o[15-k], where ien_o is {high register, low register}, so bit 7 of the high register enables source 0. A disabled source stays pending and raises its request once the bit is written to 1.
- R4: Among eligible sources, the lowest index wins, whatever the arrival order within a cycle. The break (index NUM_HW) ranks below every hardware source.
- R5: Hardware sources are eligible only while iflag_o is 1. A pending break is eligible regardless of iflag_o and the enable registers.
- R6: irq_req_o rises on the clock edge after an eligible source exists. While irq_req_o is 1 and take_i is 0, irq_idx_o and irq_vec_o hold steady.
- R7: irq_vec_o is 0xFFFA - 2*k for hardware source k. For the break it is 0xFFDE, which is the table-call 0 vector.
- R8: A take (take_i high while irq_req_o is 1) drops irq_req_o and clears iflag_o. It sets bflag_o when the taken index is the break and clears bflag_o otherwise.
- R9: A table-call 0 pulse (tcall0_i) clears bflag_o.
- R10: ei_i sets iflag_o. reti_i loads iflag_o and bflag_o from reti_iflag_i and reti_bflag_i. A take has precedence over both, and reti_i has precedence over ei_i.
- R11: After a take, setting iflag_o again lets a pending, enabled, higher-priority source raise a new request before any return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_HW | Hardware request lines, index 0 is highest priority |
| brk_i | input | 1 | Software break request pulse |
| ien_hi_we_i | input | 1 | Write strobe for the high enable register |
| ien_lo_we_i | input | 1 | Write strobe for the low enable register |
| ien_wdata_i | input | 8 | Write data for the enable registers |
| ei_i | input | 1 | Enable-interrupt pulse, sets I |
| reti_i | input | 1 | Return-from-interrupt pulse, restores I and B |
| reti_iflag_i | input | 1 | Saved I value restored on return |
| reti_bflag_i | input | 1 | Saved B value restored on return |
| tcall0_i | input | 1 | Table-call 0 pulse, clears B |
| take_i | input | 1 | Core accepts the presented request |
| irq_req_o | output | 1 | Request presented to the core |
| irq_idx_o | output | IDX_W | Index of the presented source |
| irq_vec_o | output | 16 | Vector address of the presented source |
| iflag_o | output | 1 | Global interrupt-enable flag |
| bflag_o | output | 1 | Break flag |
| ien_o | output | 16 | Enable registers, {high, low} |

## Verification
The assertions assume that the core pulses take_i only while irq_req_o is high, and that it never asserts take_i in the same cycle as ei_i or reti_i. They also assume the break is a single-cycle pulse. The bench drives every control input as a one-cycle pulse from its own tasks. It raises take_i only after it has seen irq_req_o high. It sends enable, return and table-call pulses only in cycles with no take, so every sweep over sources, pairs and masks stays inside those assumptions.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  // Source of the last status-flag update, brought out for observation.
  typedef enum logic [1:0] {
    PSW_HOLD = 2'd0,
    PSW_EI   = 2'd1,
    PSW_RETI = 2'd2,
    PSW_TAKE = 2'd3
  } psw_cause_e;

  // Position of the enable bit of hardware source k inside {hi, lo}.
  function automatic int unsigned ien_bit_of(input int unsigned k);
    return 15 - k;
  endfunction

  // Vector address of a source index; the break shares the table-call 0 slot.
  function automatic logic [15:0] vec_of(input int unsigned idx,
                                         input int unsigned num_hw,
                                         input logic [15:0] hw_top,
                                         input logic [15:0] brk_vec);
    if (idx >= num_hw) return brk_vec;
    return hw_top - 16'(2 * idx);
  endfunction

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NUM_HW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] line_i,
  input  logic              brk_i,
  input  logic [NUM_HW:0]   clr_i,
  output logic [NUM_HW:0]   pend_o
);

  logic [NUM_HW-1:0] line_q;
  logic [NUM_HW-1:0] rise_w;

  assign rise_w = line_i & ~line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_i;
  end

  // One pending flag per hardware source; a new edge wins over a clear.
  for (genvar k = 0; k < NUM_HW; k++) begin : g_hw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_o[k] <= 1'b0;
      else if (rise_w[k]) pend_o[k] <= 1'b1;
      else if (clr_i[k])  pend_o[k] <= 1'b0;
    end
  end

  // Break request is a pulse from the core; same set-over-clear rule.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend_o[NUM_HW] <= 1'b0;
    else if (brk_i)          pend_o[NUM_HW] <= 1'b1;
    else if (clr_i[NUM_HW])  pend_o[NUM_HW] <= 1'b0;
  end

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NUM_HW = 12,
  parameter int IDX_W  = 4
) (
  input  logic [NUM_HW:0]   pend_i,
  input  logic [NUM_HW-1:0] mask_i,
  input  logic              iflag_i,
  output logic [NUM_HW:0]   grant_o,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic [NUM_HW:0]   elig_w;
  logic [NUM_HW+1:0] any_above_w;

  // Hardware sources need their enable bit and the global flag.
  for (genvar k = 0; k < NUM_HW; k++) begin : g_elig
    assign elig_w[k] = pend_i[k] & mask_i[k] & iflag_i;
  end
  // The break ignores both gates.
  assign elig_w[NUM_HW] = pend_i[NUM_HW];

  // Fixed polling chain: index 0 first, break last.
  assign any_above_w[0] = 1'b0;
  for (genvar k = 0; k <= NUM_HW; k++) begin : g_chain
    assign grant_o[k]       = elig_w[k] & ~any_above_w[k];
    assign any_above_w[k+1] = any_above_w[k] | elig_w[k];
  end

  assign valid_o = any_above_w[NUM_HW+1];

  always_comb begin
    idx_o = '0;
    for (int k = 0; k <= NUM_HW; k++) begin
      if (grant_o[k]) idx_o = idx_o | IDX_W'(k);
    end
  end

endmodule

// File: rtl/irq_psw.sv
module irq_psw
  import irq_nest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  logic       take_brk_i,
  input  logic       ei_i,
  input  logic       reti_i,
  input  logic       reti_iflag_i,
  input  logic       reti_bflag_i,
  input  logic       tcall0_i,
  output logic       iflag_o,
  output logic       bflag_o,
  output psw_cause_e cause_o
);

  psw_cause_e cause_w;

  always_comb begin
    if (take_i)      cause_w = PSW_TAKE;
    else if (reti_i) cause_w = PSW_RETI;
    else if (ei_i)   cause_w = PSW_EI;
    else             cause_w = PSW_HOLD;
  end

  assign cause_o = cause_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iflag_o <= 1'b0;
      bflag_o <= 1'b0;
    end else begin
      case (cause_w)
        PSW_TAKE: begin
          iflag_o <= 1'b0;
          bflag_o <= take_brk_i;
        end
        PSW_RETI: begin
          iflag_o <= reti_iflag_i;
          bflag_o <= reti_bflag_i;
        end
        PSW_EI: begin
          iflag_o <= 1'b1;
          if (tcall0_i) bflag_o <= 1'b0;
        end
        default: begin
          if (tcall0_i) bflag_o <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int          NUM_HW  = 12,
  parameter logic [15:0] HW_TOP  = 16'hFFFA,
  parameter logic [15:0] BRK_VEC = 16'hFFDE,
  parameter int          IDX_W   = $clog2(NUM_HW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] irq_i,
  input  logic              brk_i,
  input  logic              ien_hi_we_i,
  input  logic              ien_lo_we_i,
  input  logic [7:0]        ien_wdata_i,
  input  logic              ei_i,
  input  logic              reti_i,
  input  logic              reti_iflag_i,
  input  logic              reti_bflag_i,
  input  logic              tcall0_i,
  input  logic              take_i,
  output logic              irq_req_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic [15:0]       irq_vec_o,
  output logic              iflag_o,
  output logic              bflag_o,
  output logic [15:0]       ien_o
);

  localparam logic [IDX_W-1:0] BRK_IDX = IDX_W'(NUM_HW);

  logic [7:0]        ien_hi_q;
  logic [7:0]        ien_lo_q;
  logic [15:0]       ien_w;
  logic [NUM_HW-1:0] mask_w;
  logic [NUM_HW:0]   pend_w;
  logic [NUM_HW:0]   clr_w;
  logic [NUM_HW:0]   grant_w;
  logic              win_valid_w;
  logic [IDX_W-1:0]  win_idx_w;
  logic              req_q;
  logic [IDX_W-1:0]  idx_q;
  logic              take_fire_w;
  logic              take_brk_w;
  psw_cause_e        psw_cause_w;

  // Enable registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_hi_q <= '0;
      ien_lo_q <= '0;
    end else begin
      if (ien_hi_we_i) ien_hi_q <= ien_wdata_i;
      if (ien_lo_we_i) ien_lo_q <= ien_wdata_i;
    end
  end

  assign ien_w = {ien_hi_q, ien_lo_q};
  assign ien_o = ien_w;

  for (genvar k = 0; k < NUM_HW; k++) begin : g_mask
    assign mask_w[k] = ien_w[ien_bit_of(k)];
  end

  // Handshake events.
  assign take_fire_w = take_i & req_q;
  assign take_brk_w  = take_fire_w & (idx_q == BRK_IDX);

  for (genvar k = 0; k <= NUM_HW; k++) begin : g_clr
    assign clr_w[k] = take_fire_w & (idx_q == IDX_W'(k));
  end

  irq_pend #(.NUM_HW(NUM_HW)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (irq_i),
    .brk_i  (brk_i),
    .clr_i  (clr_w),
    .pend_o (pend_w)
  );

  irq_prio #(.NUM_HW(NUM_HW), .IDX_W(IDX_W)) u_prio (
    .pend_i  (pend_w),
    .mask_i  (mask_w),
    .iflag_i (iflag_o),
    .grant_o (grant_w),
    .valid_o (win_valid_w),
    .idx_o   (win_idx_w)
  );

  irq_psw u_psw (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_i       (take_fire_w),
    .take_brk_i   (take_brk_w),
    .ei_i         (ei_i),
    .reti_i       (reti_i),
    .reti_iflag_i (reti_iflag_i),
    .reti_bflag_i (reti_bflag_i),
    .tcall0_i     (tcall0_i),
    .iflag_o      (iflag_o),
    .bflag_o      (bflag_o),
    .cause_o      (psw_cause_w)
  );

  // Presented request: frozen until taken, no arbitration meanwhile.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
    end else if (take_fire_w) begin
      req_q <= 1'b0;
    end else if (!req_q && win_valid_w) begin
      req_q <= 1'b1;
      idx_q <= win_idx_w;
    end
  end

  assign irq_req_o = req_q;
  assign irq_idx_o = idx_q;
  assign irq_vec_o = vec_of(int'(idx_q), NUM_HW, HW_TOP, BRK_VEC);

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int NUM_HW = 12,
  parameter int IDX_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [IDX_W-1:0] irq_idx,
  input logic             take,
  input logic             iflag,
  input logic             bflag,
  input logic             tcall0,
  input logic             reti,
  input logic [NUM_HW:0]  grant,
  input logic             win_valid
);

  localparam logic [IDX_W-1:0] BRK_IDX = IDX_W'(NUM_HW);

  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !take |=> irq_req && $stable(irq_idx));

  a_r6_win_raises: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && win_valid |=> irq_req);

  a_r5_hw_needs_i: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) && irq_idx != BRK_IDX |-> $past(iflag));

  a_r8_take_clears_i: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && take |=> !iflag && !irq_req);

  a_r8_brk_sets_b: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && take && irq_idx == BRK_IDX |=> bflag);

  a_r8_hw_clears_b: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && take && irq_idx != BRK_IDX |=> !bflag);

  a_r9_tcall_clears_b: assert property (@(posedge clk) disable iff (!rst_n)
    tcall0 && !reti && !(irq_req && take) |=> !bflag);

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.NUM_HW(NUM_HW), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req_o),
  .irq_idx   (irq_idx_o),
  .take      (take_i),
  .iflag     (iflag_o),
  .bflag     (bflag_o),
  .tcall0    (tcall0_i),
  .reti      (reti_i),
  .grant     (grant_w),
  .win_valid (win_valid_w)
);

// File: tb/irq_nest_ctrl_bench.sv
`timescale 1ns/1ps
module irq_nest_ctrl_bench;

  localparam int NHW = 12;
  localparam int IW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NHW-1:0] irq_i = '0;
  logic           brk_i = 1'b0;
  logic           ien_hi_we_i = 1'b0;
  logic           ien_lo_we_i = 1'b0;
  logic [7:0]     ien_wdata_i = '0;
  logic           ei_i = 1'b0;
  logic           reti_i = 1'b0;
  logic           reti_iflag_i = 1'b0;
  logic           reti_bflag_i = 1'b0;
  logic           tcall0_i = 1'b0;
  logic           take_i = 1'b0;
  logic           irq_req_o;
  logic [IW-1:0]  irq_idx_o;
  logic [15:0]    irq_vec_o;
  logic           iflag_o;
  logic           bflag_o;
  logic [15:0]    ien_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl u_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .brk_i(brk_i),
    .ien_hi_we_i(ien_hi_we_i), .ien_lo_we_i(ien_lo_we_i),
    .ien_wdata_i(ien_wdata_i), .ei_i(ei_i), .reti_i(reti_i),
    .reti_iflag_i(reti_iflag_i), .reti_bflag_i(reti_bflag_i),
    .tcall0_i(tcall0_i), .take_i(take_i), .irq_req_o(irq_req_o),
    .irq_idx_o(irq_idx_o), .irq_vec_o(irq_vec_o), .iflag_o(iflag_o),
    .bflag_o(bflag_o), .ien_o(ien_o)
  );

  function automatic logic [15:0] exp_vec(input int idx);
    return (idx == NHW) ? 16'hFFDE : 16'(32'hFFFA - 2 * idx);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_en(input logic [7:0] hi, input logic [7:0] lo);
    ien_hi_we_i = 1'b1; ien_wdata_i = hi; step(); ien_hi_we_i = 1'b0;
    ien_lo_we_i = 1'b1; ien_wdata_i = lo; step(); ien_lo_we_i = 1'b0;
  endtask

  task automatic do_ei();
    ei_i = 1'b1; step(); ei_i = 1'b0;
  endtask

  task automatic do_take();
    take_i = 1'b1; step(); take_i = 1'b0;
  endtask

  // Pulse a set of lines; afterwards the sources are pending.
  task automatic pulse(input logic [NHW-1:0] m);
    irq_i = irq_i | m; step(); irq_i = irq_i & ~m;
  endtask

  task automatic expect_req(input string req, input int idx);
    chk(req, 32'(irq_req_o), 32'd1);
    chk(req, 32'(irq_idx_o), 32'(idx));
    chk("R7", 32'(irq_vec_o), 32'(exp_vec(idx)));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    #12;
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1", 32'(irq_req_o), 32'd0);
    chk("R1", 32'(iflag_o), 32'd0);
    chk("R1", 32'(bflag_o), 32'd0);
    chk("R1", 32'(ien_o), 32'd0);

    set_en(8'hFF, 8'hF0);
    chk("R3", 32'(ien_o), 32'hFFF0);
    do_ei();
    chk("R10", 32'(iflag_o), 32'd1);

    // R2/R7/R8: every hardware source on its own
    for (int k = 0; k < NHW; k++) begin
      pulse(NHW'(1) << k);
      step();
      expect_req("R2", k);
      do_take();
      chk("R8", 32'(irq_req_o), 32'd0);
      chk("R8", 32'(iflag_o), 32'd0);
      chk("R8", 32'(bflag_o), 32'd0);
      do_ei();
    end

    // R4: every pair arriving together, lower index first
    for (int a = 0; a < NHW; a++) begin
      for (int b = a + 1; b < NHW; b++) begin
        pulse((NHW'(1) << a) | (NHW'(1) << b));
        step();
        expect_req("R4", a);
        do_take();
        do_ei();
        step();
        expect_req("R4", b);
        do_take();
        do_ei();
      end
    end

    // R3: each source masked, stays pending, served after enabling
    for (int k = 0; k < NHW; k++) begin
      logic [15:0] en;
      en = 16'hFFF0 & ~(16'h1 << (15 - k));
      set_en(en[15:8], en[7:0]);
      pulse(NHW'(1) << k);
      step(); step();
      chk("R3", 32'(irq_req_o), 32'd0);
      set_en(8'hFF, 8'hF0);
      step();
      expect_req("R3", k);
      do_take();
      do_ei();
    end

    // R5: break wins while I is clear, over a pending hardware source
    pulse(NHW'(1) << 9);
    step();
    expect_req("R5", 9);
    do_take();
    pulse(NHW'(1) << 2);
    step();
    chk("R5", 32'(irq_req_o), 32'd0);
    brk_i = 1'b1; step(); brk_i = 1'b0;
    step();
    expect_req("R5", NHW);
    chk("R7", 32'(irq_vec_o), 32'hFFDE);
    do_take();
    chk("R8", 32'(bflag_o), 32'd1);
    chk("R8", 32'(iflag_o), 32'd0);
    tcall0_i = 1'b1; step(); tcall0_i = 1'b0;
    chk("R9", 32'(bflag_o), 32'd0);
    // R10 return restores I and B; pending source 2 then fires
    reti_i = 1'b1; reti_iflag_i = 1'b1; reti_bflag_i = 1'b1; step();
    reti_i = 1'b0; reti_iflag_i = 1'b0; reti_bflag_i = 1'b0;
    chk("R10", 32'(iflag_o), 32'd1);
    chk("R10", 32'(bflag_o), 32'd1);
    step();
    expect_req("R10", 2);
    do_take();
    // R10 reti over ei in the same cycle
    reti_i = 1'b1; ei_i = 1'b1; step(); reti_i = 1'b0; ei_i = 1'b0;
    chk("R10", 32'(iflag_o), 32'd0);
    // R4 break under hardware with both pending
    do_ei();
    brk_i = 1'b1; pulse(NHW'(1) << 11); brk_i = 1'b0;
    step();
    expect_req("R4", 11);
    do_take();
    do_ei();
    step();
    expect_req("R4", NHW);
    do_take();
    chk("R8", 32'(bflag_o), 32'd1);
    do_ei();

    // R11: nesting inside the handler of source 4
    pulse(NHW'(1) << 4);
    step();
    expect_req("R11", 4);
    do_take();
    set_en(8'h80, 8'h00);
    pulse(NHW'(1) << 0);
    step();
    chk("R11", 32'(irq_req_o), 32'd0);
    do_ei();
    step();
    expect_req("R11", 0);
    do_take();
    set_en(8'hFF, 8'hF0);
    do_ei();

    // R2: held line gives one request only
    irq_i[6] = 1'b1;
    step(); step();
    expect_req("R2", 6);
    do_take();
    do_ei();
    step(); step(); step();
    chk("R2", 32'(irq_req_o), 32'd0);
    irq_i[6] = 1'b0;
    step();

    // R6: request held while not taken
    pulse(NHW'(1) << 3);
    step();
    pulse(NHW'(1) << 1);
    step(); step();
    expect_req("R6", 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule